// File: doc/BRIEF.md
# Line Clock Status Register

This block is a periodic line-time clock with a single 16-bit status register on a word-addressed bus. A tick source sets a monitor flag. The flag can raise an interrupt when software has enabled it. The tick comes from one of two places, chosen by the `src_sel` pin. One is an internal divider that fires once every `TICK_CYCLES` clock cycles. The other is the falling edge of an external line-frequency input, which passes through a synchroniser first.

Software reads the register to see whether a tick has happened since the last look. The read itself clears the flag, so no write is needed to acknowledge. A write loads the low byte, which includes the interrupt enable. The `bus_init` pin returns everything to zero.

There is no data stream at this block's edge, so there is no valid/ready handshake. Every pin is a plain control or status signal. `rd_en` and `wr_en` are single-cycle strobes and are never stalled. Read data is combinational from the register during the cycle of the read.

Top module: `lclk_status`

## Requirements
- R1: After `rst_n` low or a cycle with `bus_init` high, `rd_data` reads 0 and `irq` is 0. The internal divider and the line synchroniser restart as well.
- R2: A cycle with `wr_en` high loads `wr_data[7:0]` into `rd_data[7:0]` from the next cycle on. `rd_data[15:8]` always reads 0 whatever was written.
- R3: With `src_sel`=0, the internal tick fires in every `TICK_CYCLES`-th cycle after reset, and fires first in cycle `TICK_CYCLES`-1. If enable bit 6 is 1, the tick sets monitor flag bit 7 at the following edge.
- R4: A tick while bit 6 is 0 leaves bit 7 unchanged.
- R5: During a read cycle (`rd_en`), `rd_data` shows the current value. Bit 7 is 0 from the next cycle on, unless a tick in that same cycle sets it again.
- R6: When an enabled tick and a read fall in the same cycle, bit 7 is 1 afterwards, so the tick is not lost.
- R7: With `src_sel`=1, ticks come only from falling edges of `line_in` after a two-flop synchroniser. A fall seen before edge k sets the flag at edge k+2. Rising edges and the internal divider have no effect.
- R8: `irq` is high for exactly one cycle, in the first cycle where bit 7 reads 1 after having read 0, and only if bit 6 is 1 in that cycle.
- R9: A write in the same cycle as a tick wins: the register takes exactly the written byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_init | input | 1 | Synchronous bus initialise, clears all state |
| src_sel | input | 1 | Tick source: 0 internal divider, 1 external line input |
| line_in | input | 1 | Asynchronous line-frequency input |
| rd_en | input | 1 | Status register read strobe |
| wr_en | input | 1 | Status register write strobe |
| wr_data | input | 16 | Write data, only the low byte is stored |
| rd_data | output | 16 | Register value, bit 7 monitor flag, bit 6 enable |
| irq | output | 1 | One-cycle interrupt request |

## Verification
The hardest situations to reach from the ports are a read or a write landing in exactly the cycle of an internal tick. The bench reaches them through its own reference model of the divider phase. It waits until the model shows the counter one cycle before wrap, and then issues the read or write strobe. External-mode falls are produced with slow `line_in` toggles mixed with random glitches. Random reads, writes and occasional `bus_init` run throughout, and the model is compared every cycle.

// File: rtl/lclk_pkg.sv
package lclk_pkg;
  localparam int REG_W    = 16;
  localparam int BYTE_W   = 8;
  localparam int FLAG_BIT = 7;
  localparam int IE_BIT   = 6;
endpackage

// File: rtl/lclk_tick_gen.sv
module lclk_tick_gen #(
  parameter int TICK_CYCLES = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_init,
  input  logic src_sel,
  input  logic line_in,
  output logic tick
);
  localparam int CNT_W = (TICK_CYCLES > 2) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TICK_CYCLES - 1);

  logic [CNT_W-1:0]       cnt_q;
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   int_tick, ext_tick;

  assign int_tick = (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (bus_init) cnt_q <= '0;
    else if (int_tick) cnt_q <= '0;
    else               cnt_q <= cnt_q + CNT_W'(1);
  end

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        sync_q[0] <= 1'b0;
        else if (bus_init) sync_q[0] <= 1'b0;
        else               sync_q[0] <= line_in;
      end
    end else begin : g_rest
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        sync_q[s] <= 1'b0;
        else if (bus_init) sync_q[s] <= 1'b0;
        else               sync_q[s] <= sync_q[s-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        prev_q <= 1'b0;
    else if (bus_init) prev_q <= 1'b0;
    else               prev_q <= sync_q[SYNC_STAGES-1];
  end

  assign ext_tick = prev_q & ~sync_q[SYNC_STAGES-1];
  assign tick     = src_sel ? ext_tick : int_tick;
endmodule

// File: rtl/lclk_status_reg.sv
module lclk_status_reg
  import lclk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_init,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_byte,
  input  logic              tick,
  output logic [BYTE_W-1:0] stat_q,
  output logic              irq_q
);
  logic [BYTE_W-1:0] stat_d;

  always_comb begin
    stat_d = stat_q;
    if (wr_en) begin
      stat_d = wr_byte;
    end else begin
      if (rd_en)                stat_d[FLAG_BIT] = 1'b0;
      if (tick && stat_q[IE_BIT]) stat_d[FLAG_BIT] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      irq_q  <= 1'b0;
    end else if (bus_init) begin
      stat_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      stat_q <= stat_d;
      irq_q  <= stat_d[FLAG_BIT] & ~stat_q[FLAG_BIT] & stat_d[IE_BIT];
    end
  end
endmodule

// File: rtl/lclk_status.sv
module lclk_status
  import lclk_pkg::*;
#(
  parameter int TICK_CYCLES = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_init,
  input  logic             src_sel,
  input  logic             line_in,
  input  logic             rd_en,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  output logic             irq
);
  logic              tick_w;
  logic [BYTE_W-1:0] stat_w;
  logic              unused_hi;

  assign unused_hi = ^wr_data[REG_W-1:BYTE_W];

  lclk_tick_gen #(
    .TICK_CYCLES(TICK_CYCLES),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_tick (
    .clk(clk), .rst_n(rst_n), .bus_init(bus_init),
    .src_sel(src_sel), .line_in(line_in), .tick(tick_w)
  );

  lclk_status_reg u_reg (
    .clk(clk), .rst_n(rst_n), .bus_init(bus_init),
    .rd_en(rd_en), .wr_en(wr_en), .wr_byte(wr_data[BYTE_W-1:0]),
    .tick(tick_w), .stat_q(stat_w), .irq_q(irq)
  );

  assign rd_data = {{(REG_W-BYTE_W){1'b0}}, stat_w};
endmodule

// File: rtl/lclk_status_chk.sv
module lclk_status_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_init,
  input logic        rd_en,
  input logic        wr_en,
  input logic [15:0] wr_data,
  input logic [15:0] rd_data,
  input logic        irq,
  input logic        tick
);
  p_init_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    bus_init |=> (rd_data == 16'h0) && !irq);
  p_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[15:8] == 8'h0);
  p_write_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !bus_init) |=> rd_data[7:0] == $past(wr_data[7:0]));
  p_tick_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && rd_data[6] && !wr_en && !bus_init) |=> rd_data[7]);
  p_no_ie_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !rd_data[6] && !wr_en && !rd_en && !bus_init) |=> $stable(rd_data[7]));
  p_read_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !tick && !wr_en && !bus_init) |=> !rd_data[7]);
  p_irq_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  p_irq_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (rd_data[7] && rd_data[6] && !$past(rd_data[7])));
endmodule

bind lclk_status lclk_status_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_init(bus_init), .rd_en(rd_en),
  .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .irq(irq),
  .tick(tick_w)
);

// File: tb/lclk_status_bench.sv
module lclk_status_bench;
  localparam int TICK = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_init = 1'b0, src_sel = 1'b0, line_in = 1'b0;
  logic        rd_en = 1'b0, wr_en = 1'b0;
  logic [15:0] wr_data = 16'h0;
  logic [15:0] rd_data;
  logic        irq;

  int checks = 0, errors = 0;
  string cur_req = "R1";
  bit running = 1'b0;

  logic [7:0] m_reg = 8'h0;
  logic       m_irq = 1'b0;
  int         m_cnt = 0;
  logic       m_s1 = 1'b0, m_s2 = 1'b0, m_prev = 1'b0;

  always #2 clk = ~clk;

  lclk_status #(.TICK_CYCLES(TICK)) u_lclk_status (
    .clk(clk), .rst_n(rst_n), .bus_init(bus_init), .src_sel(src_sel),
    .line_in(line_in), .rd_en(rd_en), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .irq(irq)
  );

  function automatic logic [7:0] next_byte(logic [7:0] cur, logic wr, logic rd,
                                           logic [7:0] wd, logic tk);
    logic [7:0] n;
    n = cur;
    if (wr) n = wd;
    else begin
      if (rd) n[7] = 1'b0;
      if (tk && cur[6]) n[7] = 1'b1;
    end
    return n;
  endfunction

  always @(posedge clk) begin
    logic tk_int, tk_ext, tk;
    logic [7:0] n;
    running <= 1'b1;
    if (!rst_n || bus_init) begin
      m_reg = 8'h0; m_irq = 1'b0; m_cnt = 0;
      m_s1 = 1'b0; m_s2 = 1'b0; m_prev = 1'b0;
    end else begin
      tk_int = (m_cnt == TICK - 1);
      tk_ext = m_prev && !m_s2;
      tk     = src_sel ? tk_ext : tk_int;
      m_cnt  = tk_int ? 0 : m_cnt + 1;
      m_prev = m_s2; m_s2 = m_s1; m_s1 = line_in;
      n      = next_byte(m_reg, wr_en, rd_en, wr_data[7:0], tk);
      m_irq  = n[7] && !m_reg[7] && n[6];
      m_reg  = n;
    end
  end

  task automatic check(input bit ok, input string req, input logic [15:0] act,
                       input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (running) begin
      check(rd_data === {8'h0, m_reg}, cur_req, rd_data, {8'h0, m_reg});
      check(irq === m_irq, {cur_req, " irq R8"}, {15'h0, irq}, {15'h0, m_irq});
    end
  end

  task automatic drive(input logic rd, input logic wr, input logic [15:0] d);
    @(posedge clk); #1;
    rd_en = rd; wr_en = wr; wr_data = d; bus_init = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(1'b0, 1'b0, 16'h0);
  endtask

  task automatic wait_pre_tick();
    do drive(1'b0, 1'b0, 16'h0); while (m_cnt != TICK - 2);
  endtask

  initial begin
    #120000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h1c3b));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    cur_req = "R1";
    idle(2);
    check(rd_data === 16'h0 && irq === 1'b0, "R1 reset", rd_data, 16'h0);
    cur_req = "R2"; drive(1'b0, 1'b1, 16'hFF3C); idle(2);
    check(rd_data === 16'h003C, "R2 write", rd_data, 16'h003C);
    cur_req = "R4"; drive(1'b0, 1'b1, 16'h0000); idle(3 * TICK);
    check(rd_data[7] === 1'b0, "R4 disabled tick", rd_data, 16'h0);
    cur_req = "R3"; drive(1'b0, 1'b1, 16'h0040); idle(2 * TICK);
    check(rd_data[7] === 1'b1, "R3 flag set", rd_data, 16'h00C0);
    cur_req = "R5"; wait_pre_tick(); idle(1); drive(1'b1, 1'b0, 16'h0); idle(1);
    check(rd_data[7] === 1'b0, "R5 read clear", rd_data, 16'h0040);
    cur_req = "R6"; idle(TICK); wait_pre_tick(); drive(1'b1, 1'b0, 16'h0); idle(1);
    check(rd_data[7] === 1'b1, "R6 read at tick", rd_data, 16'h00C0);
    cur_req = "R9"; wait_pre_tick(); drive(1'b0, 1'b1, 16'h0041); idle(1);
    check(rd_data === 16'h0041, "R9 write at tick", rd_data, 16'h0041);
    cur_req = "R7"; src_sel = 1'b1; drive(1'b1, 1'b1, 16'h0040); idle(3 * TICK);
    check(rd_data[7] === 1'b0, "R7 no line fall", rd_data, 16'h0040);
    line_in = 1'b1; idle(6);
    check(rd_data[7] === 1'b0, "R7 rising ignored", rd_data, 16'h0040);
    line_in = 1'b0; idle(6);
    check(rd_data[7] === 1'b1, "R7 falling sets", rd_data, 16'h00C0);
    cur_req = "R1"; @(posedge clk); #1 bus_init = 1'b1; idle(1);
    check(rd_data === 16'h0 && irq === 1'b0, "R1 bus init", rd_data, 16'h0);
    cur_req = "R8";
    for (int k = 0; k < 3000; k++) begin
      int r = $urandom_range(0, 99);
      if (r < 2)        begin @(posedge clk); #1 bus_init = 1'b1; rd_en = 1'b0; wr_en = 1'b0; end
      else if (r < 8)   drive(1'b0, 1'b1, 16'($urandom));
      else if (r < 20)  drive(1'b1, 1'b0, 16'h0);
      else              drive(1'b0, 1'b0, 16'h0);
      if ($urandom_range(0, 199) == 0) src_sel = ~src_sel;
      if ($urandom_range(0, 9) == 0) line_in = ~line_in;
    end
    idle(2);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule